// File: doc/BRIEF.md
# Pointer-Addressed Serial Management Slave

This block is a slave on a two-wire serial management bus. It gives a host access to a byte-wide internal register space through a pointer register. The bus lines are sampled with the system clock, synchronized and filtered. Bus conditions and clock edges are then decoded from the cleaned lines. The slave drives the data line only through an open-drain enable.

A transfer opens with a START and an address byte. The slave answers to a 7-bit address whose upper five bits are fixed. Its two low bits come from a three-level strap, which is captured only while reset is held.

- In a write, the first data byte always goes to the pointer. A second byte is stored in the register the pointer selects.
- A read returns the register at the current pointer. A read with no write before it therefore reuses the last pointer.
- The register file sits outside the block. It is reached through an address, a write-data bus, a one-cycle write strobe and a read-data bus.

Top module: `smb_ptr_slave`

## Requirements
- R1: While reset is held and after it ends, the data line is released and the write strobe is low. The pointer starts at 0, so a read straight after reset returns register 0.
- R2: The slave address is 0101 1 followed by two strap bits. Strap code 2'b00 (tied low) selects low bits 10. Code 2'b01 (floating) selects 00. Code 2'b10 (tied high) selects 01, and 2'b11 acts as floating. The strap is captured only while reset is held, and later strap changes do not alter the address.
- R3: In a write to the slave's address, every byte up to the second data byte is acknowledged. The first data byte loads the pointer. The second drives the write strobe high for exactly one cycle, with that byte on the write-data bus and the pointer on the address bus.
- R4: A read to the slave's address is acknowledged, and the slave returns the register selected by the pointer, MSB first. A read with no pointer write before it uses the pointer left by the last write.
- R5: An address byte that does not match gets no acknowledge. Until the next START, further bytes get no acknowledge, cause no register write and leave the pointer unchanged.
- R6: In a write, the third and later data bytes are not acknowledged and write nothing.
- R7: When the master acknowledges a read byte, the slave sends the register at the same pointer again. When the master does not acknowledge, the slave releases the data line and waits for STOP or START.
- R8: The slave changes its data-line drive only while the filtered clock line is low. It releases the line after the ninth clock of each byte.
- R9: A pulse on either bus line shorter than FILT_LEN system clocks has no effect on the decoded bus.
- R10: A repeated START in the middle of a transfer restarts the address phase. The read/write bit of the new address byte sets the direction.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Active-low synchronous reset; the strap is sampled while it is low |
| scl_i | input | 1 | Serial clock line as seen on the bus |
| sda_i | input | 1 | Serial data line as seen on the bus |
| strap_i | input | 2 | Three-level strap code: 00 low, 01 floating, 10 high |
| sda_oe | output | 1 | 1 pulls the data line low (open drain) |
| reg_addr | output | 8 | Register address, equal to the pointer |
| reg_wdata | output | 8 | Data for a register write |
| reg_we | output | 1 | One-cycle register write strobe |
| reg_rdata | input | 8 | Data of the register at reg_addr |

## Verification
The bench covers the following corner cases:

- **Strap timing.** It resets with each strap level and then moves the strap without a reset. A design that follows the live strap would acknowledge the wrong address.
- **Write length.** It sends a foreign address followed by data, and a write with a third data byte. A slave that kept counting bytes after a mismatch, or that wrote extra bytes, would produce an unexpected register write. That write shows up in the write scoreboard.
- **Read continuation.** Reads are tested after a repeated START, with a master acknowledge, and with no pointer write before them. A design that advanced or reset the pointer would return the wrong byte.
- **Glitch filtering.** A one-cycle clock glitch is placed inside a data byte. A design without filtering would shift in an extra bit and store a corrupted value.

// File: rtl/smb_pkg.sv
package smb_pkg;

    localparam int BYTE_W = 8;
    localparam int ADDR_W = 7;
    localparam int BIT_CW = $clog2(BYTE_W + 1);

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RX,
        ST_ACK,
        ST_TX,
        ST_TXACK,
        ST_HOLD
    } smb_state_e;

    typedef enum logic [1:0] {
        BY_ADDR,
        BY_PTR,
        BY_DATA,
        BY_EXTRA
    } byte_kind_e;

    typedef struct packed {
        smb_state_e        st;
        byte_kind_e        kind;
        logic              rd;
        logic [BIT_CW-1:0] cnt;
        logic [BYTE_W-1:0] sh;
        logic [BYTE_W-1:0] ptr;
        logic              oe;
        logic              we;
        logic [BYTE_W-1:0] wdata;
        logic              mack;
        logic              scl_p;
        logic              sda_p;
    } core_s;

    // three-level strap code to the two low address bits
    function automatic logic [1:0] strap_to_bits(input logic [1:0] code);
        case (code)
            2'b00:   return 2'b10;
            2'b10:   return 2'b01;
            default: return 2'b00;
        endcase
    endfunction

endpackage

// File: rtl/smb_line_filter.sv
module smb_line_filter #(
    parameter int FILT_LEN = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_i,
    output logic line_o
);
    localparam int CW = $clog2(FILT_LEN + 1);
    localparam logic [CW-1:0] CNT_TOP = CW'(FILT_LEN - 1);

    typedef struct packed {
        logic          s0;
        logic          s1;
        logic [CW-1:0] cnt;
        logic          out;
    } filt_s;

    localparam filt_s FILT_RST = '{s0: 1'b1, s1: 1'b1, cnt: '0, out: 1'b1};

    filt_s q, d;

    always_comb begin
        d    = q;
        d.s0 = line_i;
        d.s1 = q.s0;
        if (q.s1 != q.out) begin
            if (q.cnt == CNT_TOP) begin
                d.out = q.s1;
                d.cnt = '0;
            end else begin
                d.cnt = q.cnt + 1'b1;
            end
        end else begin
            d.cnt = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= FILT_RST;
        else        q <= d;
    end

    assign line_o = q.out;

    AST_FILT_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        (q.out != $past(q.out)) |-> ($past(q.s1) == q.out)); // R9

endmodule

// File: rtl/smb_slave_core.sv
module smb_slave_core
    import smb_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl,
    input  logic              sda,
    input  logic [ADDR_W-1:0] dev_addr,
    input  logic [BYTE_W-1:0] rdata,
    output logic              sda_oe,
    output logic [BYTE_W-1:0] addr,
    output logic [BYTE_W-1:0] wdata,
    output logic              we
);
    localparam logic [BIT_CW-1:0] CNT_FULL = BIT_CW'(BYTE_W);
    localparam logic [BIT_CW-1:0] CNT_LAST = BIT_CW'(BYTE_W - 1);

    localparam core_s CORE_RST = '{
        st: ST_IDLE, kind: BY_ADDR, rd: 1'b0, cnt: '0, sh: '0, ptr: '0,
        oe: 1'b0, we: 1'b0, wdata: '0, mack: 1'b0, scl_p: 1'b1, sda_p: 1'b1};

    core_s q, d;
    logic  scl_rise, scl_fall, bus_start, bus_stop;

    always_comb begin
        scl_rise  = scl & ~q.scl_p;
        scl_fall  = ~scl & q.scl_p;
        bus_start = scl & q.scl_p & q.sda_p & ~sda;
        bus_stop  = scl & q.scl_p & ~q.sda_p & sda;

        d       = q;
        d.we    = 1'b0;
        d.scl_p = scl;
        d.sda_p = sda;

        if (bus_start) begin
            d.st   = ST_RX;
            d.kind = BY_ADDR;
            d.cnt  = '0;
            d.oe   = 1'b0;
        end else if (bus_stop) begin
            d.st = ST_IDLE;
            d.oe = 1'b0;
        end else begin
            case (q.st)
                ST_RX: begin
                    if (scl_rise) begin
                        d.sh  = {q.sh[BYTE_W-2:0], sda};
                        d.cnt = q.cnt + 1'b1;
                    end else if (scl_fall && q.cnt == CNT_FULL) begin
                        d.st = ST_ACK;
                        case (q.kind)
                            BY_ADDR: begin
                                if (q.sh[BYTE_W-1:1] == dev_addr) begin
                                    d.rd = q.sh[0];
                                    d.oe = 1'b1;
                                end else begin
                                    d.st = ST_HOLD;
                                end
                            end
                            BY_PTR: begin
                                d.ptr = q.sh;
                                d.oe  = 1'b1;
                            end
                            BY_DATA: begin
                                d.we    = 1'b1;
                                d.wdata = q.sh;
                                d.oe    = 1'b1;
                            end
                            default: d.oe = 1'b0;
                        endcase
                    end
                end
                ST_ACK: begin
                    if (scl_fall) begin
                        d.cnt = '0;
                        if (q.rd) begin
                            d.st = ST_TX;
                            d.sh = rdata;
                            d.oe = ~rdata[BYTE_W-1];
                        end else begin
                            d.st = ST_RX;
                            d.oe = 1'b0;
                            case (q.kind)
                                BY_ADDR: d.kind = BY_PTR;
                                BY_PTR:  d.kind = BY_DATA;
                                default: d.kind = BY_EXTRA;
                            endcase
                        end
                    end
                end
                ST_TX: begin
                    if (scl_fall) begin
                        if (q.cnt == CNT_LAST) begin
                            d.st = ST_TXACK;
                            d.oe = 1'b0;
                        end else begin
                            d.sh  = {q.sh[BYTE_W-2:0], 1'b0};
                            d.cnt = q.cnt + 1'b1;
                            d.oe  = ~q.sh[BYTE_W-2];
                        end
                    end
                end
                ST_TXACK: begin
                    if (scl_rise) begin
                        d.mack = ~sda;
                    end else if (scl_fall) begin
                        if (q.mack) begin
                            d.st  = ST_TX;
                            d.sh  = rdata;
                            d.cnt = '0;
                            d.oe  = ~rdata[BYTE_W-1];
                        end else begin
                            d.st = ST_HOLD;
                        end
                    end
                end
                default: d.oe = 1'b0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= CORE_RST;
        else        q <= d;
    end

    assign sda_oe = q.oe;
    assign addr   = q.ptr;
    assign wdata  = q.wdata;
    assign we     = q.we;

    AST_OE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (q.oe != $past(q.oe)) |-> !scl); // R8
    AST_WE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        q.we |=> !q.we); // R3
    AST_QUIET_STATES: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_IDLE || q.st == ST_HOLD) |-> !q.oe); // R5
    AST_PTR_FROM_PTR_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
        (q.ptr != $past(q.ptr)) |-> ($past(q.st) == ST_RX && $past(q.kind) == BY_PTR)); // R3

endmodule

// File: rtl/smb_ptr_slave.sv
module smb_ptr_slave
    import smb_pkg::*;
#(
    parameter int         FILT_LEN    = 3,
    parameter logic [4:0] ADDR_PREFIX = 5'b01011
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    input  logic [1:0]        strap_i,
    output logic              sda_oe,
    output logic [BYTE_W-1:0] reg_addr,
    output logic [BYTE_W-1:0] reg_wdata,
    output logic              reg_we,
    input  logic [BYTE_W-1:0] reg_rdata
);
    localparam int NLINES = 2;

    logic [NLINES-1:0] raw_lines;
    logic [NLINES-1:0] clean_lines;
    logic [1:0]        addr_lo_d, addr_lo_q;

    assign raw_lines = {scl_i, sda_i};

    for (genvar g = 0; g < NLINES; g++) begin : g_filt
        smb_line_filter #(.FILT_LEN(FILT_LEN)) u_filt (
            .clk    (clk),
            .rst_n  (rst_n),
            .line_i (raw_lines[g]),
            .line_o (clean_lines[g])
        );
    end

    always_comb begin
        addr_lo_d = addr_lo_q;
        if (!rst_n) addr_lo_d = strap_to_bits(strap_i);
    end

    always_ff @(posedge clk) begin
        addr_lo_q <= addr_lo_d;
    end

    smb_slave_core u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl      (clean_lines[1]),
        .sda      (clean_lines[0]),
        .dev_addr ({ADDR_PREFIX, addr_lo_q}),
        .rdata    (reg_rdata),
        .sda_oe   (sda_oe),
        .addr     (reg_addr),
        .wdata    (reg_wdata),
        .we       (reg_we)
    );

    AST_STRAP_LATCHED: assert property (@(posedge clk) disable iff (!rst_n)
        $stable(addr_lo_q)); // R2

endmodule

// File: tb/smb_ptr_slave_tb.sv
module smb_ptr_slave_tb;
    localparam int Q = 20;
    localparam logic [1:0] S_LOW = 2'b00, S_OPEN = 2'b01, S_HIGH = 2'b10;
    localparam logic [6:0] DEV = 7'h2C;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl_m = 1'b1, sda_m = 1'b1;
    logic [1:0] strap = S_OPEN;
    logic       sda_oe, reg_we;
    logic [7:0] reg_addr, reg_wdata, reg_rdata;
    logic       sda_bus;
    logic [7:0] mem [256];

    int errors = 0;
    int checks = 0;
    logic [15:0] exp_q[$];
    logic [15:0] exp_item;

    always #2 clk = ~clk;

    assign sda_bus   = sda_m & ~sda_oe;
    assign reg_rdata = mem[reg_addr];

    smb_ptr_slave u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_m),
        .sda_i     (sda_bus),
        .strap_i   (strap),
        .sda_oe    (sda_oe),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_we    (reg_we),
        .reg_rdata (reg_rdata)
    );

    function automatic logic [7:0] memv(input int i);
        return 8'(i) ^ 8'hA5;
    endfunction

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = memv(i);
    end

    always @(posedge clk) if (reg_we) mem[reg_addr] <= reg_wdata;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // scoreboard monitor: every strobe must match the oldest expected write
    always @(negedge clk) begin
        if (rst_n && reg_we) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R5/R6 unexpected write", int'({reg_addr, reg_wdata}), 0);
            end else begin
                exp_item = exp_q.pop_front();
                check({reg_addr, reg_wdata} == exp_item, "R3 write addr/data",
                      int'({reg_addr, reg_wdata}), int'(exp_item));
            end
        end
    end

    task automatic wq();
        repeat (Q) @(posedge clk);
        #1;
    endtask

    task automatic bit_out(input logic b, input bit glitch);
        sda_m = b; wq();
        scl_m = 1'b1; wq();
        if (glitch) begin
            scl_m = 1'b0; @(posedge clk); #1; scl_m = 1'b1;
        end
        wq();
        scl_m = 1'b0; wq();
    endtask

    task automatic bit_in(output logic b);
        sda_m = 1'b1; wq();
        scl_m = 1'b1; wq();
        b = sda_bus; wq();
        scl_m = 1'b0; wq();
    endtask

    task automatic send_byte(input logic [7:0] v, input int gl, output bit ack);
        logic a;
        for (int i = 7; i >= 0; i--) bit_out(v[i], i == gl);
        bit_in(a);
        ack = !a;
    endtask

    task automatic recv_byte(output logic [7:0] v, input bit mack);
        for (int i = 7; i >= 0; i--) bit_in(v[i]);
        bit_out(!mack, 1'b0);
    endtask

    task automatic start_c();
        sda_m = 1'b1; wq();
        scl_m = 1'b1; wq();
        sda_m = 1'b0; wq();
        scl_m = 1'b0; wq();
    endtask

    task automatic stop_c();
        sda_m = 1'b0; wq();
        scl_m = 1'b1; wq();
        sda_m = 1'b1; wq();
    endtask

    task automatic do_reset(input logic [1:0] s);
        rst_n = 1'b0; strap = s;
        repeat (5) @(posedge clk);
        #1 rst_n = 1'b1;
        wq();
    endtask

    task automatic addr_phase(input logic [6:0] a, input logic rw, input bit exp_ack, input string tag);
        bit ack;
        start_c();
        send_byte({a, rw}, 8, ack);
        check(ack == exp_ack, tag, int'(ack), int'(exp_ack));
    endtask

    task automatic send_chk(input logic [7:0] v, input int gl, input bit exp_ack, input string tag);
        bit ack;
        send_byte(v, gl, ack);
        check(ack == exp_ack, tag, int'(ack), int'(exp_ack));
    endtask

    task automatic read_at(input logic [7:0] exp, input string tag);
        logic [7:0] v;
        addr_phase(DEV, 1'b1, 1'b1, tag);
        recv_byte(v, 1'b0);
        check(v == exp, tag, int'(v), int'(exp));
        stop_c();
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        check(1'b0, "watchdog expired", 0, 1);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin : main
        logic [7:0] v;
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        check(sda_oe == 1'b0, "R1 sda released in reset", int'(sda_oe), 0);
        do_reset(S_OPEN);
        check(sda_oe == 1'b0, "R1 sda released after reset", int'(sda_oe), 0);
        check(reg_we == 1'b0, "R1 no strobe after reset", int'(reg_we), 0);
        read_at(memv(0), "R1 pointer starts at 0");

        // R3: pointer byte then data byte
        addr_phase(DEV, 1'b0, 1'b1, "R2 own address acked");
        send_chk(8'h10, 8, 1'b1, "R3 pointer byte acked");
        exp_q.push_back({8'h10, 8'h5A});
        send_chk(8'h5A, 8, 1'b1, "R3 data byte acked");
        stop_c();
        check(exp_q.size() == 0, "R3 write strobe seen", exp_q.size(), 0);

        // R4: pointer-only write, then reads
        addr_phase(DEV, 1'b0, 1'b1, "R4 address acked");
        send_chk(8'h33, 8, 1'b1, "R4 pointer acked");
        stop_c();
        read_at(memv(8'h33), "R4 read at pointer");
        check(sda_oe == 1'b0, "R8 released after nack", int'(sda_oe), 0);
        read_at(memv(8'h33), "R4 pointer reused");

        // R10 repeated start, R7 master ack continues at same pointer
        addr_phase(DEV, 1'b0, 1'b1, "R10 write address acked");
        send_chk(8'h10, 8, 1'b1, "R10 pointer acked");
        addr_phase(DEV, 1'b1, 1'b1, "R10 read after repeated start acked");
        recv_byte(v, 1'b1);
        check(v == 8'h5A, "R10 read after repeated start", int'(v), 'h5A);
        recv_byte(v, 1'b0);
        check(v == 8'h5A, "R7 byte after master ack", int'(v), 'h5A);
        check(sda_oe == 1'b0, "R7 released after nack", int'(sda_oe), 0);
        stop_c();

        // R5 foreign address
        addr_phase(7'h2D, 1'b0, 1'b0, "R5 foreign address not acked");
        send_chk(8'h44, 8, 1'b0, "R5 byte after mismatch not acked");
        send_chk(8'h99, 8, 1'b0, "R5 second byte after mismatch not acked");
        stop_c();
        read_at(8'h5A, "R5 pointer untouched");

        // R6 third byte dropped
        addr_phase(DEV, 1'b0, 1'b1, "R6 address acked");
        send_chk(8'h20, 8, 1'b1, "R6 pointer acked");
        exp_q.push_back({8'h20, 8'h11});
        send_chk(8'h11, 8, 1'b1, "R6 first data acked");
        send_chk(8'h22, 8, 1'b0, "R6 third byte not acked");
        stop_c();
        read_at(8'h11, "R6 extra byte not written");

        // R9 one-cycle clock glitch inside a data bit
        addr_phase(DEV, 1'b0, 1'b1, "R9 address acked");
        send_chk(8'h30, 8, 1'b1, "R9 pointer acked");
        exp_q.push_back({8'h30, 8'hC3});
        send_chk(8'hC3, 3, 1'b1, "R9 glitched byte acked");
        stop_c();
        read_at(8'hC3, "R9 glitch ignored");

        // R2 strap captured only in reset
        do_reset(S_LOW);
        addr_phase(7'h2E, 1'b0, 1'b1, "R2 strap low address acked");
        stop_c();
        addr_phase(7'h2C, 1'b0, 1'b0, "R2 floating address rejected");
        stop_c();
        strap = S_HIGH;
        wq();
        addr_phase(7'h2E, 1'b0, 1'b1, "R2 strap change ignored");
        stop_c();
        addr_phase(7'h2D, 1'b0, 1'b0, "R2 new strap not live");
        stop_c();
        do_reset(S_HIGH);
        addr_phase(7'h2D, 1'b0, 1'b1, "R2 strap high address acked");
        stop_c();

        check(exp_q.size() == 0, "R3 all expected writes seen", exp_q.size(), 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule